// File: doc/BRIEF.md
# TLB Bulk Invalidation Engine

This block sweeps a translation buffer's entry array and invalidates the entries picked out by a command. The array has two regions. The first is a set-associative region of `WAYS` ways by `SETS` lines. The second is a fully associative region of `FA_N` entries placed above it, so entry numbers run from 0 to `WAYS*SETS+FA_N-1`. The engine does not hold the array. It presents one entry number per clock on a read port and gets back that entry's valid bit, global bit, address-space id, virtual page-pair number and page size in the same cycle. For every entry the command selects, it issues a one-cycle clear strobe that carries the entry number. The array owner then writes the entry's valid bit to 0.

A request is a one-cycle `start` pulse with the command code and its operands. These are captured on acceptance: index, current ASID, ASID operand, global value, virtual address and the shared page size. The engine is busy while it walks and pulses `done` once at the end. Some commands work on one line across all ways, or on the whole associative region. Others cover the full array. The two page commands match each entry at a granularity set by that entry's effective page size.

Top module: `tlbinv_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `clr_valid` are low.
- R2: For the line commands (code 0 and code 1), an index below `WAYS*SETS` visits the entries `w*SETS + (index mod SETS)` for w = 0 to WAYS-1. An index from `WAYS*SETS` to `WAYS*SETS+FA_N-1` visits every associative entry. A larger index visits nothing.
- R3: Code 0 (line clear) strobes a visited entry only if its global bit is 0 and its ASID equals `cur_asid`. The valid bit is not consulted.
- R4: Code 1 (line flush) strobes every visited entry without any check.
- R5: Code 2 visits and strobes every entry of the array.
- R6: Code 3 strobes every entry whose global bit equals `op_g`.
- R7: Code 4 strobes every entry whose global bit is 0 and whose ASID equals `op_asid`.
- R8: The page commands (codes 5 and 6) never strobe an entry whose valid bit is 0. Such an entry is a page hit when `op_vaddr >> (ps+1)` equals `vppn >> (ps-12)`. Here ps is `shared_ps` for set-associative entries and the entry's own `ent_ps` for associative entries. `vppn` holds virtual address bits from 13 upward.
- R9: Code 5 also needs global bit 0 and ASID equal to `op_asid`. Code 6 needs either global bit 1 or ASID equal to `op_asid`.
- R10: The engine examines one entry per clock. For N visited entries, `done` is high for exactly one cycle, N+1 clock edges after the edge that accepts `start`. The strobe for the last visited entry appears in that same cycle. Each strobe is high for one cycle per entry.
- R11: A `start` pulse while `busy` is high is ignored. The running command's strobes and its completion time are unchanged.
- R12: Code 7 visits no entry. It raises `done` one edge after acceptance with no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken when not busy |
| op | input | 3 | Command code (0..7) |
| op_index | input | IDX_W | Entry index selecting the line-command scope |
| cur_asid | input | ASID_W | Current address-space id, used by code 0 |
| op_asid | input | ASID_W | ASID operand for codes 4, 5, 6 |
| op_g | input | 1 | Global value for code 3 |
| op_vaddr | input | VA_W | Virtual address for page commands |
| shared_ps | input | PS_W | Page size of all set-associative entries |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ent_rd | output | 1 | Read port request, high while walking |
| ent_idx | output | IDX_W | Entry number being examined |
| ent_e | input | 1 | Valid bit of the addressed entry |
| ent_g | input | 1 | Global bit of the addressed entry |
| ent_asid | input | ASID_W | ASID of the addressed entry |
| ent_vppn | input | VA_W-13 | Virtual page-pair number of the addressed entry |
| ent_ps | input | PS_W | Own page size of the addressed entry |
| clr_valid | output | 1 | Clear strobe |
| clr_idx | output | IDX_W | Entry to clear when `clr_valid` is high |

## Verification
The engine's state is a walk pointer, an end point, a stride mode and the captured operands. An error in any of them shows up at the strobe port while the same command is running. A bad pointer or stride strobes a wrong line or skips one. A bad end point moves the `done` pulse off the N+1 edge. Bad captured operands change which entries of a deterministic pseudo-random array get strobed. For each command, the bench compares the whole set of strobed entries with a set it derives arithmetically, so any such fault is reported on the same run that caused it. Line commands are swept across every index, including indices past the array.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [2:0] {
    OP_LINE_CLR   = 3'd0,
    OP_LINE_FLUSH = 3'd1,
    OP_ALL        = 3'd2,
    OP_ALL_G      = 3'd3,
    OP_ALL_ASID   = 3'd4,
    OP_PAGE_ASID  = 3'd5,
    OP_PAGE_AORG  = 3'd6,
    OP_NONE       = 3'd7
  } inv_op_e;

  localparam int PAGE_LSB = 13;

  function automatic logic is_page_op(inv_op_e o);
    return (o == OP_PAGE_ASID) || (o == OP_PAGE_AORG);
  endfunction

endpackage

// File: rtl/tlbinv_scope.sv
module tlbinv_scope
  import tlbinv_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 256,
  parameter int FA_N  = 64,
  parameter int IDX_W = 12
) (
  input  inv_op_e          op,
  input  logic [IDX_W-1:0] index,
  output logic [IDX_W-1:0] first,
  output logic [IDX_W-1:0] last,
  output logic             line_stride,
  output logic             empty
);
  localparam int SA_N  = WAYS * SETS;
  localparam int TOTAL = SA_N + FA_N;
  localparam int SET_W = $clog2(SETS);

  logic [IDX_W-1:0] set_base;
  assign set_base = IDX_W'(index[SET_W-1:0]);

  always_comb begin
    first       = '0;
    last        = IDX_W'(TOTAL - 1);
    line_stride = 1'b0;
    empty       = 1'b0;
    case (op)
      OP_LINE_CLR, OP_LINE_FLUSH: begin
        if (32'(index) < SA_N) begin
          first       = set_base;
          last        = IDX_W'(SA_N - SETS) + set_base;
          line_stride = 1'b1;
        end else if (32'(index) < TOTAL) begin
          first = IDX_W'(SA_N);
        end else begin
          empty = 1'b1;
        end
      end
      OP_NONE: empty = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int ASID_W = 10,
  parameter int VA_W   = 48,
  parameter int PS_W   = 6
) (
  input  inv_op_e                  op,
  input  logic                     in_sa,
  input  logic [PS_W-1:0]          shared_ps,
  input  logic [ASID_W-1:0]        cur_asid,
  input  logic [ASID_W-1:0]        op_asid,
  input  logic                     op_g,
  input  logic [VA_W-1:0]          vaddr,
  input  logic                     ent_e,
  input  logic                     ent_g,
  input  logic [ASID_W-1:0]        ent_asid,
  input  logic [VA_W-PAGE_LSB-1:0] ent_vppn,
  input  logic [PS_W-1:0]          ent_ps,
  output logic                     hit
);
  logic [PS_W-1:0] eff_ps;
  logic [VA_W-1:0] diff;
  logic            page_eq;
  logic            asid_cur_eq;
  logic            asid_op_eq;

  assign eff_ps      = in_sa ? shared_ps : ent_ps;
  assign diff        = vaddr ^ {ent_vppn, {PAGE_LSB{1'b0}}};
  assign asid_cur_eq = (ent_asid == cur_asid);
  assign asid_op_eq  = (ent_asid == op_asid);

  // Bits strictly above the effective page size select the page pair.
  always_comb begin
    page_eq = 1'b1;
    for (int i = 0; i < VA_W; i++) begin
      if (i > int'(eff_ps) && diff[i]) page_eq = 1'b0;
    end
  end

  always_comb begin
    case (op)
      OP_LINE_CLR:   hit = !ent_g && asid_cur_eq;
      OP_LINE_FLUSH: hit = 1'b1;
      OP_ALL:        hit = 1'b1;
      OP_ALL_G:      hit = (ent_g == op_g);
      OP_ALL_ASID:   hit = !ent_g && asid_op_eq;
      OP_PAGE_ASID:  hit = ent_e && !ent_g && asid_op_eq && page_eq;
      OP_PAGE_AORG:  hit = ent_e && (ent_g || asid_op_eq) && page_eq;
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 256,
  parameter int FA_N   = 64,
  parameter int ASID_W = 10,
  parameter int VA_W   = 48,
  parameter int PS_W   = 6,
  localparam int SA_N  = WAYS * SETS,
  localparam int TOTAL = SA_N + FA_N,
  localparam int IDX_W = $clog2(TOTAL),
  localparam int VPN_W = VA_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  op_index,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [ASID_W-1:0] op_asid,
  input  logic              op_g,
  input  logic [VA_W-1:0]   op_vaddr,
  input  logic [PS_W-1:0]   shared_ps,
  output logic              busy,
  output logic              done,
  output logic              ent_rd,
  output logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_e,
  input  logic              ent_g,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]  ent_vppn,
  input  logic [PS_W-1:0]   ent_ps,
  output logic              clr_valid,
  output logic [IDX_W-1:0]  clr_idx
);
  localparam int SET_W = $clog2(SETS);

  inv_op_e           op_in, op_q;
  logic [IDX_W-1:0]  sc_first, sc_last, last_q;
  logic              sc_line, sc_empty, line_q;
  logic [ASID_W-1:0] cur_asid_q, op_asid_q;
  logic              op_g_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [PS_W-1:0]   sps_q;
  logic              hit, in_sa, at_last;
  logic [IDX_W-1:0]  step;

  assign op_in   = inv_op_e'(op);
  assign ent_rd  = busy;
  assign in_sa   = 32'(ent_idx) < SA_N;
  assign at_last = (ent_idx == last_q);
  assign step    = line_q ? IDX_W'(SETS) : IDX_W'(1);

  tlbinv_scope #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .IDX_W(IDX_W)) u_scope (
    .op(op_in), .index(op_index), .first(sc_first), .last(sc_last),
    .line_stride(sc_line), .empty(sc_empty)
  );

  tlbinv_match #(.ASID_W(ASID_W), .VA_W(VA_W), .PS_W(PS_W)) u_match (
    .op(op_q), .in_sa(in_sa), .shared_ps(sps_q), .cur_asid(cur_asid_q),
    .op_asid(op_asid_q), .op_g(op_g_q), .vaddr(vaddr_q), .ent_e(ent_e),
    .ent_g(ent_g), .ent_asid(ent_asid), .ent_vppn(ent_vppn), .ent_ps(ent_ps),
    .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      clr_valid  <= 1'b0;
      clr_idx    <= '0;
      ent_idx    <= '0;
      last_q     <= '0;
      line_q     <= 1'b0;
      op_q       <= OP_NONE;
      cur_asid_q <= '0;
      op_asid_q  <= '0;
      op_g_q     <= 1'b0;
      vaddr_q    <= '0;
      sps_q      <= '0;
    end else begin
      done      <= 1'b0;
      clr_valid <= 1'b0;
      if (busy) begin
        clr_valid <= hit;
        clr_idx   <= ent_idx;
        if (at_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ent_idx <= ent_idx + step;
        end
      end else if (start) begin
        op_q       <= op_in;
        cur_asid_q <= cur_asid;
        op_asid_q  <= op_asid;
        op_g_q     <= op_g;
        vaddr_q    <= op_vaddr;
        sps_q      <= shared_ps;
        if (sc_empty) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          ent_idx <= sc_first;
          last_q  <= sc_last;
          line_q  <= sc_line;
        end
      end
    end
  end

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (32'(ent_idx) < TOTAL));

  assert_line_column_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && line_q) |-> (clr_idx[SET_W-1:0] == last_q[SET_W-1:0]));

  assert_page_skip_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && is_page_op(op_q)) |-> $past(ent_e));

  assert_strobe_from_visit_R10: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> $past(busy));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !at_last) |=> (busy && $stable(op_q) && $stable(last_q)));
endmodule

// File: tb/tlbinv_engine_tb.sv
`timescale 1ns/1ps
module tlbinv_engine_tb;
  localparam int WAYS = 4, SETS = 16, FA_N = 8;
  localparam int SA_N = WAYS * SETS, TOTAL = SA_N + FA_N;
  localparam int IDX_W = $clog2(TOTAL);
  localparam int ASID_W = 10, VA_W = 48, PS_W = 6, VPN_W = VA_W - 13;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] op = 3'd7;
  logic [IDX_W-1:0] op_index = '0;
  logic [ASID_W-1:0] cur_asid = '0, op_asid = '0;
  logic op_g = 1'b0;
  logic [VA_W-1:0] op_vaddr = '0;
  logic [PS_W-1:0] shared_ps = 6'd12;
  logic busy, done, ent_rd, clr_valid, ent_e, ent_g;
  logic [IDX_W-1:0] ent_idx, clr_idx;
  logic [ASID_W-1:0] ent_asid;
  logic [VPN_W-1:0] ent_vppn;
  logic [PS_W-1:0] ent_ps;

  logic m_e [TOTAL];
  logic m_g [TOTAL];
  logic [ASID_W-1:0] m_asid [TOTAL];
  logic [VPN_W-1:0] m_vppn [TOTAL];
  logic [PS_W-1:0] m_ps [TOTAL];
  logic got [TOTAL];
  logic want [TOTAL];
  int dups;
  int total = 0, bad = 0;
  logic [31:0] rs = 32'h1badf00d;

  always #4 clk = ~clk;

  tlbinv_engine #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .op_index(op_index),
    .cur_asid(cur_asid), .op_asid(op_asid), .op_g(op_g), .op_vaddr(op_vaddr),
    .shared_ps(shared_ps), .busy(busy), .done(done), .ent_rd(ent_rd),
    .ent_idx(ent_idx), .ent_e(ent_e), .ent_g(ent_g), .ent_asid(ent_asid),
    .ent_vppn(ent_vppn), .ent_ps(ent_ps), .clr_valid(clr_valid), .clr_idx(clr_idx)
  );

  wire ok_idx = 32'(ent_idx) < TOTAL;
  assign ent_e    = ok_idx ? m_e[ent_idx] : 1'b0;
  assign ent_g    = ok_idx ? m_g[ent_idx] : 1'b0;
  assign ent_asid = ok_idx ? m_asid[ent_idx] : '0;
  assign ent_vppn = ok_idx ? m_vppn[ent_idx] : '0;
  assign ent_ps   = ok_idx ? m_ps[ent_idx] : '0;

  always @(negedge clk) begin
    if (!rst && clr_valid) begin
      if (32'(clr_idx) >= TOTAL) dups++;
      else begin
        if (got[clr_idx]) dups++;
        got[clr_idx] = 1'b1;
      end
    end
  end

  function automatic logic [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic fill();
    for (int i = 0; i < TOTAL; i++) begin
      logic [31:0] r;
      r = rnd();
      m_e[i]    = r[0] | r[1];
      m_g[i]    = r[2];
      m_asid[i] = ASID_W'(r[5:4]);
      m_vppn[i] = VPN_W'(35'h1234500 + 35'(r[11:6]));
      m_ps[i]   = (i < SA_N) ? 6'd63 : PS_W'(12 + r[14:12]);
    end
  endtask

  function automatic logic page_hit(int i);
    logic [63:0] va, vp;
    int ps;
    ps = (i < SA_N) ? int'(shared_ps) : int'(m_ps[i]);
    va = 64'(op_vaddr);
    vp = 64'(m_vppn[i]);
    return (va >> (ps + 1)) == (vp >> (ps - 12));
  endfunction

  function automatic logic visited(int o, int idx, int i);
    if (o == 7) return 1'b0;
    if (o >= 2) return 1'b1;
    if (idx < SA_N) return (i < SA_N) && ((i % SETS) == (idx % SETS));
    if (idx < TOTAL) return i >= SA_N;
    return 1'b0;
  endfunction

  function automatic logic expect_hit(int o, int i);
    case (o)
      0: return !m_g[i] && (m_asid[i] == cur_asid);
      1, 2: return 1'b1;
      3: return m_g[i] == op_g;
      4: return !m_g[i] && (m_asid[i] == op_asid);
      5: return m_e[i] && !m_g[i] && (m_asid[i] == op_asid) && page_hit(i);
      6: return m_e[i] && (m_g[i] || (m_asid[i] == op_asid)) && page_hit(i);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(logic cond, string tag, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_op(int o, int idx, string tag, bit inject);
    int n, k, mism, first_bad;
    n = 0;
    for (int i = 0; i < TOTAL; i++) begin
      logic v;
      v = visited(o, idx, i);
      if (v) n++;
      want[i] = v && expect_hit(o, i);
      got[i] = 1'b0;
    end
    dups = 0;
    @(negedge clk);
    op = 3'(o); op_index = IDX_W'(idx); start = 1'b1;
    k = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      op = 3'(o);
      k++;
      if (inject && k == 3) begin op = 3'd2; start = 1'b1; end
      if (done || k > 5000) break;
    end
    #1;
    check(k == n + 1, tag, $sformatf("done edge op=%0d idx=%0d", o, idx), k, n + 1);
    mism = 0; first_bad = -1;
    for (int i = 0; i < TOTAL; i++)
      if (got[i] !== want[i]) begin mism++; if (first_bad < 0) first_bad = i; end
    check(mism == 0 && dups == 0, tag,
          $sformatf("strobe set op=%0d idx=%0d first_bad=%0d dups=%0d", o, idx, first_bad, dups),
          mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !clr_valid, "R1", "outputs after reset",
          {busy, done, clr_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !clr_valid, "R1", "idle after release",
          {busy, done, clr_valid}, 0);

    // R2, R3, R4, R10: line commands over every index, including out-of-range ones
    for (int idx = 0; idx < TOTAL + 4; idx++) begin
      fill();
      cur_asid = ASID_W'(idx % 4);
      run_op(0, idx, "R3", 1'b0);
      run_op(1, idx, "R4", 1'b0);
    end
    run_op(1, 2**IDX_W - 1, "R2", 1'b0);

    // R5: everything
    fill(); run_op(2, 0, "R5", 1'b0);
    // R6: by global value
    for (int g = 0; g < 2; g++) begin fill(); op_g = g[0]; run_op(3, 0, "R6", 1'b0); end
    // R7: by ASID operand
    for (int a = 0; a < 4; a++) begin fill(); op_asid = ASID_W'(a); run_op(4, 0, "R7", 1'b0); end

    // R8, R9: page commands with varied addresses and shared page sizes
    for (int t = 0; t < 12; t++) begin
      logic [31:0] r;
      fill();
      r = rnd();
      shared_ps = PS_W'(12 + (t % 4));
      op_asid   = ASID_W'(r[15:14]);
      op_vaddr  = {VPN_W'(35'h1234500 + 35'(r[5:0])), r[28:16]};
      run_op(5, 0, "R9", 1'b0);
      run_op(6, 0, "R8", 1'b0);
    end

    // R12: undefined code
    fill(); run_op(7, 0, "R12", 1'b0);

    // R11: start while busy must not disturb the running command
    fill(); op_asid = 10'd1; run_op(4, 0, "R11", 1'b1);
    fill(); cur_asid = 10'd2; run_op(0, 5, "R11", 1'b1);

    repeat (3) @(negedge clk);
    check(!busy && !done && !clr_valid, "R10", "quiet after last done",
          {busy, done, clr_valid}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule